// File: doc/BRIEF.md
# Preemptible ADC Chain Sequencer

This block schedules conversions for an eight-channel converter that serves two chains of work. The normal chain converts the channels selected by its enable mask, either once per start request or in a repeating scan. The injected chain has higher priority. When an injected start arrives while a normal channel is being converted, that normal channel is abandoned. The whole injected chain then runs, the abandoned channel is converted again, and the rest of the normal pass follows.

The sequencer drives the converter through three signals: a channel number, a sample-phase strobe and a convert-phase strobe. The two phases last a fixed number of cycles, set by parameters. At the end of the convert phase the block captures the converter's data word into that channel's result register. For each channel it keeps a result-valid bit and an end-of-conversion pending flag. Each chain also has its own end-of-chain flag.

Software controls the block through start pulses, a scan-mode level, a single-channel abort pulse and a chain abort pulse.

Top module: `adc_chain_seq`

## Requirements
- R1: Within a chain pass, the enabled channels are converted in ascending channel order, each exactly once. Each conversion holds `conv_sample` high for SAMPLE_CYC cycles (4 by default) and then `conv_active` high for CONV_CYC cycles (8 by default). `conv_ch` stays stable throughout, and at least one idle cycle separates two conversions.
- R2: An injected start while a normal channel is converting abandons that channel. All injected channels then convert, followed by the abandoned normal channel and the remaining normal channels. No normal conversion is launched while injected work is pending. An injected start while the injected chain is already active is ignored.
- R3: A pulse on `abort_ch` during an injected conversion discards only that channel. The sequencer then moves on to the next injected channel or, when there is none, to the restored normal channel.
- R4: Bit n of `eoc_pend` is set only when a conversion of channel n runs to its end. A channel that was preempted or discarded gets no flag until it completes. After a complete pass, mask AND (mask XOR `eoc_pend`) is zero. Writing 1 to bit n of `eoc_clr` clears bit n, and a completion in the same cycle wins over the clear.
- R5: `nrm_eoc` is raised once at the end of each normal pass, including a pass whose last channel was preempted. `inj_eoc` is raised once at the end of each injected chain.
- R6: With `scan_mode` low, `nrm_busy` clears when a normal pass finishes. With `scan_mode` high, a new pass starts at once from the lowest enabled channel and `nrm_busy` stays high.
- R7: `abort_chain` during a conversion stops the chain that owns that conversion and raises its end-of-chain flag. For the normal chain in scan mode, the next pass starts from the lowest enabled channel and runs through the highest, with no channel repeated or skipped.
- R8: A normal start while `nrm_busy` is high leaves the current pass unchanged. It is held and begins a full pass from the lowest enabled channel once the current pass ends.
- R9: `abort_ch` or `abort_chain` while no conversion is running has no effect: no flag is raised and later starts convert normally.
- R10: At the end of a completed conversion of channel n, the 12-bit `conv_data` word is stored for channel n and its valid bit is set. `rd_data`/`rd_valid` show the entry selected by `rd_ch`, and a cycle with `rd_en` high clears that entry's valid bit.
- R11: The end-of-chain flags are write-1-to-clear: bit 0 of `eoc_flag_clr` clears `nrm_eoc` and bit 1 clears `inj_eoc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_mode | input | 1 | 1 = normal chain repeats, 0 = one pass per start |
| nrm_mask | input | NCH | Normal chain channel enables |
| inj_mask | input | NCH | Injected chain channel enables |
| nrm_start | input | 1 | Start pulse for the normal chain |
| inj_start | input | 1 | Start pulse for the injected chain |
| abort_ch | input | 1 | Discard the conversion in progress |
| abort_chain | input | 1 | Stop the chain owning the conversion in progress |
| conv_ch | output | log2(NCH) | Channel driven to the converter |
| conv_inj | output | 1 | Current conversion belongs to the injected chain |
| conv_sample | output | 1 | Sample phase strobe |
| conv_active | output | 1 | Convert phase strobe |
| conv_data | input | DW | Converter result, captured on the last convert cycle |
| nrm_busy | output | 1 | Normal chain start status |
| eoc_pend | output | NCH | Per-channel end-of-conversion pending flags |
| eoc_clr | input | NCH | Write-1-to-clear for `eoc_pend` |
| nrm_eoc | output | 1 | Normal end-of-chain flag |
| inj_eoc | output | 1 | Injected end-of-chain flag |
| eoc_flag_clr | input | 2 | Write-1-to-clear for the end-of-chain flags |
| rd_ch | input | log2(NCH) | Result register select |
| rd_en | input | 1 | Read strobe that clears the selected valid bit |
| rd_data | output | DW | Selected result |
| rd_valid | output | 1 | Valid bit of the selected result |

## Verification
The hardest cases to reach depend on exactly where an abort or preemption lands: inside the last channel of a normal pass, inside the middle channel of the injected chain, or inside a scan pass already in progress. The stimulus waits at the ports for the converter strobes to show the target chain and channel in its convert phase, then fires the pulse. A scoreboard queue holds the full expected launch order, including restored and restarted channels. Counted end-of-chain flags and the pending mask are then compared against the expected values.

// File: rtl/adc_chain_seq.sv
module adc_chain_seq #(
  parameter int NCH        = 8,
  parameter int DW         = 12,
  parameter int SAMPLE_CYC = 4,
  parameter int CONV_CYC   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_mode,
  input  logic [NCH-1:0]         nrm_mask,
  input  logic [NCH-1:0]         inj_mask,
  input  logic                   nrm_start,
  input  logic                   inj_start,
  input  logic                   abort_ch,
  input  logic                   abort_chain,
  output logic [$clog2(NCH)-1:0] conv_ch,
  output logic                   conv_inj,
  output logic                   conv_sample,
  output logic                   conv_active,
  input  logic [DW-1:0]          conv_data,
  output logic                   nrm_busy,
  output logic [NCH-1:0]         eoc_pend,
  input  logic [NCH-1:0]         eoc_clr,
  output logic                   nrm_eoc,
  output logic                   inj_eoc,
  input  logic [1:0]             eoc_flag_clr,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid
);
  localparam int CW   = $clog2(NCH);
  localparam int CNTW = $clog2(SAMPLE_CYC + CONV_CYC);

  typedef enum logic [1:0] {P_IDLE, P_SAMP, P_CONV} phase_t;

  phase_t          phase;
  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   cur_ch;
  logic            cur_inj;
  logic [NCH-1:0]  nrm_rem, inj_rem, vld;
  logic            nrm_req;
  logic [DW-1:0]   res [NCH];

  function automatic logic [CW-1:0] lowest(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = CW'(i);
    return r;
  endfunction

  logic           busy_conv, done, retire, fin_ok, preempt, launch, pick_inj;
  logic           inj_go, inj_end, pass_end, restart;
  logic [NCH-1:0] cur_bit, rd_bit, inj_left, nrm_left;
  logic [CW-1:0]  next_ch;

  assign busy_conv = phase != P_IDLE;
  assign done      = phase == P_CONV && cnt == CNTW'(CONV_CYC - 1);
  assign retire    = busy_conv && (done || abort_ch || abort_chain);
  assign fin_ok    = done && !abort_ch && !abort_chain;
  assign preempt   = busy_conv && !cur_inj && !retire && |inj_rem;
  assign cur_bit   = {{(NCH-1){1'b0}}, 1'b1} << cur_ch;
  assign rd_bit    = {{(NCH-1){1'b0}}, 1'b1} << rd_ch;
  assign inj_left  = abort_chain ? '0 : inj_rem & ~cur_bit;
  assign nrm_left  = abort_chain ? '0 : nrm_rem & ~cur_bit;
  assign inj_end   = retire && cur_inj && inj_left == '0;
  assign pass_end  = retire && !cur_inj && nrm_left == '0;
  assign restart   = pass_end && (scan_mode || nrm_req || nrm_start) && |nrm_mask;
  assign inj_go    = inj_start && inj_rem == '0 && |inj_mask;
  assign pick_inj  = |inj_rem;
  assign next_ch   = pick_inj ? lowest(inj_rem) : lowest(nrm_rem);
  assign launch    = !busy_conv && (|inj_rem || |nrm_rem);

  assign conv_ch     = cur_ch;
  assign conv_inj    = cur_inj;
  assign conv_sample = phase == P_SAMP;
  assign conv_active = phase == P_CONV;
  assign rd_data     = res[rd_ch];
  assign rd_valid    = vld[rd_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      cur_ch  <= '0;
      cur_inj <= 1'b0;
    end else if (launch) begin
      phase   <= P_SAMP;
      cnt     <= '0;
      cur_ch  <= next_ch;
      cur_inj <= pick_inj;
    end else if (retire || preempt) begin
      phase <= P_IDLE;
      cnt   <= '0;
    end else if (phase == P_SAMP && cnt == CNTW'(SAMPLE_CYC - 1)) begin
      phase <= P_CONV;
      cnt   <= '0;
    end else if (busy_conv) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_rem  <= '0;
      nrm_rem  <= '0;
      nrm_busy <= 1'b0;
      nrm_req  <= 1'b0;
      nrm_eoc  <= 1'b0;
      inj_eoc  <= 1'b0;
      eoc_pend <= '0;
    end else begin
      if (retire && cur_inj) inj_rem <= inj_left;
      else if (inj_go)       inj_rem <= inj_mask;

      if (pass_end) begin
        nrm_req  <= 1'b0;
        nrm_rem  <= restart ? nrm_mask : '0;
        nrm_busy <= restart;
      end else begin
        if (retire && !cur_inj) nrm_rem <= nrm_left;
        if (nrm_start && !nrm_busy && |nrm_mask) begin
          nrm_busy <= 1'b1;
          nrm_rem  <= nrm_mask;
        end else if (nrm_start && nrm_busy) begin
          nrm_req <= 1'b1;
        end
      end

      nrm_eoc  <= (nrm_eoc & ~eoc_flag_clr[0]) | pass_end;
      inj_eoc  <= (inj_eoc & ~eoc_flag_clr[1]) | inj_end;
      eoc_pend <= (eoc_pend & ~eoc_clr) | (fin_ok ? cur_bit : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      vld <= (vld & ~(rd_en ? rd_bit : '0)) | (fin_ok ? cur_bit : '0);
      if (fin_ok) res[cur_ch] <= conv_data;
    end
  end

  // R1
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_sample || conv_active) && $past(conv_sample || conv_active) |-> $stable(conv_ch));
  // R1
  conv_after_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> $past(conv_sample));
  // R2
  inj_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_sample) && !conv_inj |-> $past(inj_rem) == '0);
  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(eoc_pend & ~$past(eoc_pend)) |-> $past(conv_active && !abort_ch && !abort_chain));
  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nrm_busy) |-> nrm_eoc);
  // R7
  inj_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_chain && conv_inj && (conv_sample || conv_active) |=> inj_eoc);
  // R9
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ch || abort_chain) && !conv_sample && !conv_active |=> !$rose(nrm_eoc) && !$rose(inj_eoc));
endmodule

// File: tb/sim_adc_chain_seq.sv
`timescale 1ns/1ps
module sim_adc_chain_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_mode = 1'b0;
  logic [7:0] nrm_mask = '0, inj_mask = '0;
  logic       nrm_start = 1'b0, inj_start = 1'b0, abort_ch = 1'b0, abort_chain = 1'b0;
  logic [2:0] conv_ch;
  logic       conv_inj, conv_sample, conv_active, nrm_busy, nrm_eoc, inj_eoc, rd_valid;
  logic [11:0] conv_data, rd_data;
  logic [7:0] eoc_pend;
  logic [7:0] eoc_clr = '0;
  logic [1:0] eoc_flag_clr = '0;
  logic [2:0] rd_ch = '0;
  logic       rd_en = 1'b0;

  int checks = 0, errors = 0;
  int nrm_ends = 0, inj_ends = 0;
  logic [3:0] exp_q[$];
  logic prev_s = 1'b0;

  always #2 clk = ~clk;

  assign conv_data = {conv_inj, 4'h0, conv_ch, 4'h5};

  adc_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .nrm_mask(nrm_mask), .inj_mask(inj_mask),
    .nrm_start(nrm_start), .inj_start(inj_start), .abort_ch(abort_ch), .abort_chain(abort_chain),
    .conv_ch(conv_ch), .conv_inj(conv_inj), .conv_sample(conv_sample), .conv_active(conv_active),
    .conv_data(conv_data), .nrm_busy(nrm_busy), .eoc_pend(eoc_pend), .eoc_clr(eoc_clr),
    .nrm_eoc(nrm_eoc), .inj_eoc(inj_eoc), .eoc_flag_clr(eoc_flag_clr),
    .rd_ch(rd_ch), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic push(input bit inj, input int ch); exp_q.push_back({inj, 3'(ch)}); endtask

  // scoreboard monitor: every launched conversion must match the next expected item
  always @(negedge clk) begin
    if (rst_n && conv_sample && !prev_s) begin
      if (exp_q.size() == 0) check("R1 unexpected launch", 1'b0, {conv_inj, conv_ch}, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check("R1/R2 launch order", e == {conv_inj, conv_ch}, {conv_inj, conv_ch}, e);
      end
    end
    prev_s = conv_sample;
  end

  // end-of-chain flag counter; clears each flag it sees (R11)
  always @(negedge clk) begin
    if (!rst_n) eoc_flag_clr = '0;
    else begin
      if (eoc_flag_clr[0]) check("R11 nrm_eoc cleared", nrm_eoc == 1'b0, nrm_eoc, 0);
      if (eoc_flag_clr[1]) check("R11 inj_eoc cleared", inj_eoc == 1'b0, inj_eoc, 0);
      eoc_flag_clr = '0;
      if (nrm_eoc) begin nrm_ends++; eoc_flag_clr[0] = 1'b1; end
      if (inj_eoc) begin inj_ends++; eoc_flag_clr[1] = 1'b1; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic clear_pend();
    eoc_clr = '1; tick(); eoc_clr = '0;
    check("R4 pend w1c", eoc_pend == 8'h00, eoc_pend, 0);
  endtask

  task automatic pulse_nrm(); nrm_start = 1'b1; tick(); nrm_start = 1'b0; endtask
  task automatic pulse_inj(); inj_start = 1'b1; tick(); inj_start = 1'b0; endtask

  task automatic wait_nrm_conv(input bit inj, input int ch);
    while (!(conv_active && conv_inj == inj && conv_ch == 3'(ch))) tick();
  endtask

  task automatic settle();
    repeat (3) tick();
    check("R1 queue drained", exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    int n, m, base_n, base_i;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R6 reset busy", nrm_busy == 1'b0, nrm_busy, 0);
    check("R4 reset pend", eoc_pend == 8'h00, eoc_pend, 0);
    check("R1 reset strobes", {conv_sample, conv_active} == 2'b00, {conv_sample, conv_active}, 0);

    // one-shot normal pass, channels 0,2,5,7
    nrm_mask = 8'b1010_0101; base_n = nrm_ends;
    push(0,0); push(0,2); push(0,5); push(0,7);
    pulse_nrm();
    while (!conv_sample) tick();
    n = 0; while (conv_sample) begin n++; tick(); end
    m = 0; while (conv_active) begin m++; tick(); end
    check("R1 sample cycles", n == 4, n, 4);
    check("R1 convert cycles", m == 8, m, 8);
    while (nrm_busy) tick();
    settle();
    check("R6 one-shot busy clear", nrm_busy == 1'b0, nrm_busy, 0);
    check("R5 one nrm_eoc", nrm_ends == base_n + 1, nrm_ends, base_n + 1);
    check("R4 pend matches mask", (nrm_mask & (nrm_mask ^ eoc_pend)) == 0, eoc_pend, nrm_mask);
    rd_ch = 3'd5; #1;
    check("R10 valid set", rd_valid == 1'b1, rd_valid, 1);
    check("R10 data", rd_data == 12'h055, rd_data, 12'h055);
    rd_en = 1'b1; tick(); rd_en = 1'b0; #1;
    check("R10 valid cleared on read", rd_valid == 1'b0, rd_valid, 0);
    clear_pend();

    // preemption in the middle of the normal chain
    nrm_mask = 8'b0000_1111; inj_mask = 8'b1100_0000;
    base_n = nrm_ends; base_i = inj_ends;
    push(0,0); push(0,1); push(1,6); push(1,7); push(0,1); push(0,2); push(0,3);
    pulse_nrm();
    wait_nrm_conv(0, 1);
    pulse_inj();
    while (inj_ends == base_i) tick();
    check("R4 preempted flag not yet set", eoc_pend[1] == 1'b0, eoc_pend[1], 0);
    while (nrm_busy) tick();
    settle();
    check("R2 pend all", eoc_pend == 8'hCF, eoc_pend, 8'hCF);
    check("R5 nrm_eoc once", nrm_ends == base_n + 1, nrm_ends, base_n + 1);
    check("R5 inj_eoc once", inj_ends == base_i + 1, inj_ends, base_i + 1);
    clear_pend();

    // preemption on the last normal channel
    base_n = nrm_ends;
    push(0,0); push(0,1); push(0,2); push(0,3); push(1,6); push(1,7); push(0,3);
    pulse_nrm();
    wait_nrm_conv(0, 3);
    pulse_inj();
    while (nrm_busy) tick();
    settle();
    check("R5 no duplicate eoc on last-channel preempt", nrm_ends == base_n + 1, nrm_ends, base_n + 1);
    clear_pend();

    // single-channel abort inside the injected chain
    nrm_mask = 8'b0000_0011; inj_mask = 8'b0111_0000; base_i = inj_ends;
    push(0,0); push(1,4); push(1,5); push(1,6); push(0,0); push(0,1);
    pulse_nrm();
    wait_nrm_conv(0, 0);
    pulse_inj();
    wait_nrm_conv(1, 5);
    abort_ch = 1'b1; tick(); abort_ch = 1'b0;
    while (nrm_busy) tick();
    settle();
    check("R3 only ch5 discarded", eoc_pend == 8'h53, eoc_pend, 8'h53);
    check("R3 inj chain ended", inj_ends == base_i + 1, inj_ends, base_i + 1);
    clear_pend();

    // scan mode with a chain abort in the second pass
    nrm_mask = 8'b0001_1100; scan_mode = 1'b1; base_n = nrm_ends;
    push(0,2); push(0,3); push(0,4); push(0,2); push(0,3); push(0,2); push(0,3); push(0,4);
    pulse_nrm();
    while (nrm_ends == base_n) tick();
    check("R6 scan busy stays", nrm_busy == 1'b1, nrm_busy, 1);
    wait_nrm_conv(0, 3);
    abort_chain = 1'b1; tick(); abort_chain = 1'b0;
    while (nrm_ends < base_n + 2) tick();
    check("R7 abort_chain eoc", nrm_ends == base_n + 2, nrm_ends, base_n + 2);
    scan_mode = 1'b0;
    while (nrm_busy) tick();
    settle();
    check("R7 clean pass after abort", nrm_ends == base_n + 3, nrm_ends, base_n + 3);
    clear_pend();

    // start while busy is held for a clean pass
    nrm_mask = 8'b0000_0111; base_n = nrm_ends;
    push(0,0); push(0,1); push(0,2); push(0,0); push(0,1); push(0,2);
    pulse_nrm();
    wait_nrm_conv(0, 1);
    pulse_nrm();
    while (nrm_busy) tick();
    settle();
    check("R8 two passes", nrm_ends == base_n + 2, nrm_ends, base_n + 2);
    clear_pend();

    // aborts while idle are ignored
    base_n = nrm_ends; base_i = inj_ends;
    abort_ch = 1'b1; tick(); abort_ch = 1'b0;
    abort_chain = 1'b1; tick(); abort_chain = 1'b0;
    repeat (10) tick();
    check("R9 no nrm flag", nrm_ends == base_n, nrm_ends, base_n);
    check("R9 no inj flag", inj_ends == base_i, inj_ends, base_i);
    inj_mask = 8'b1000_0001;
    push(1,0); push(1,7);
    pulse_inj();
    while (inj_ends == base_i) tick();
    settle();
    check("R9 injected runs after idle aborts", eoc_pend == 8'h81, eoc_pend, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule